// File: doc/BRIEF.md
# Set-Associative TLB Lookup Unit

This block translates a 32-bit virtual address into a physical address. It uses a translation buffer with 16 sets of 4 ways and an 8 KB page. A request gives the address, a write flag, the current process ID and the MMU configuration word. One cycle after the request is accepted, the block returns one of two results: the physical address built from the stored frame number, or one of four fault vectors (miss, invalid entry, foreign process, write-protect).

On every fault a cause word records the faulting page, the access type and the process ID. On a miss, a refill-select word is loaded with the missing set index, so that software can write the replacement entry. The translation entries live in a register array inside the block. A plain load port fills that array one entry at a time.

Requests enter on a valid/ready channel and results leave on a valid/ready channel. A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. `req_ready` is high whenever no result is pending or the pending result is being taken in the same cycle. A result is presented with `rsp_valid` and stays stable until `rsp_ready` is high at a rising edge, so a stalled consumer stalls the requester too. The load port, the enable, the configuration and the process ID are plain level inputs.

Top module: `tlb_lookup`

## Requirements
- R1: After reset, `rsp_valid` is 0, `cause_q` is 0 and `refill_sel` is 0.
- R2: When `mmu_en` is 0, an accepted request returns `rsp_paddr` equal to `req_vaddr` with `rsp_fault`=0 and `rsp_vec`=0. `cause_q` and `refill_sel` do not change.
- R3: The page number is vaddr[31:13] and the set index is vaddr[16:13]. A way hits when its stored page number matches. A hit that passes every check returns {frame number, vaddr[12:0]} with `rsp_fault`=0 and `rsp_vec`=0. The result is valid in the cycle after acceptance.
- R4: When no way of the indexed set matches, the result is a miss: `rsp_vec`=0x8, `rsp_fault`=1 and `rsp_paddr`=0. `refill_sel` becomes {2'b00, set index}, with the way field in bits 5:4 and the index in bits 3:0.
- R5: On a hit where config bit 16 is set and the entry's valid flag (low-word bit 3) is clear, `rsp_vec`=0x9.
- R6: On a hit where the global flag (low-word bit 4) is clear and the entry's PID (high-word bits 7:0) is neither 0xFF nor `cur_pid`, `rsp_vec`=0xA.
- R7: On a write that hits an entry whose write flag (low-word bit 1) is clear while config bit 19 is set, `rsp_vec`=0xB. A read of the same entry does not fault.
- R8: Fault priority is miss, then invalid, then PID, then write-protect. When several ways match, the lowest-numbered way is used.
- R9: On any fault with `mmu_en`=1, `cause_q` becomes {page number in 31:13, 3'b000, access type in 9:8, `cur_pid` in 7:0}. The access type is 2'b01 for a read and 2'b10 for a write. On a non-faulting access `cause_q` keeps its value.
- R10: `refill_sel` changes only on a miss. Any other fault or hit leaves it unchanged.
- R11: While `rsp_valid`=1 and `rsp_ready`=0, the result outputs stay unchanged and `req_ready`=0.
- R12: With `ld_en`=1 at a rising edge, the entry at set `ld_set`, way `ld_way` takes `ld_hi` and `ld_lo`. The high word holds the page number in bits 31:13 and the PID in bits 7:0. The low word holds the frame number in bits 31:13 and the flags G=4, V=3, K=2, W=1, X=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmu_en | input | 1 | Translation enable; 0 passes addresses through |
| mmu_cfg | input | 32 | Check enables: bit 16 valid, 17 execute, 18 kernel, 19 write |
| cur_pid | input | 8 | Current process ID |
| ld_en | input | 1 | Entry load strobe |
| ld_way | input | 2 | Way to load |
| ld_set | input | 4 | Set to load |
| ld_hi | input | 32 | Entry high word (page number, PID) |
| ld_lo | input | 32 | Entry low word (frame number, flags) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 1 | Translation failed |
| rsp_vec | output | 4 | Fault vector: 0 none, 8 miss, 9 invalid, A PID, B write-protect |
| cause_q | output | 32 | Fault cause word |
| refill_sel | output | 6 | Refill select: way in 5:4, set index in 3:0 |

## Verification
The bench loads entries whose page numbers come from a small tag pool, so random addresses hit, miss and alias often. Mixed flags, PIDs and check enables make two or more faults apply to the same access. A wrong priority order would report, for example, a PID fault on an entry that is also invalid. Selecting the highest matching way would return the wrong frame when two ways share a tag. Directed cases check that `refill_sel` stays unchanged across faults other than a miss, and that `cause_q` survives hits. A design that updated either word on every access would fail these cases. A stalled consumer is held while a second request waits. A design that overwrote or dropped the pending result would show a changed address, or the second result would never appear.

// File: rtl/tlbl_pkg.sv
package tlbl_pkg;
  localparam int ADDR_W    = 32;
  localparam int PAGE_BITS = 13;
  localparam int VPN_W     = ADDR_W - PAGE_BITS;
  localparam int PID_W     = 8;

  localparam int FLG_X = 0;
  localparam int FLG_W = 1;
  localparam int FLG_K = 2;
  localparam int FLG_V = 3;
  localparam int FLG_G = 4;

  localparam int CFG_V = 16;
  localparam int CFG_X = 17;
  localparam int CFG_K = 18;
  localparam int CFG_W = 19;

  localparam logic [PID_W-1:0] PID_ANY = 8'hFF;

  localparam logic [3:0] VEC_NONE = 4'h0;
  localparam logic [3:0] VEC_MISS = 4'h8;
  localparam logic [3:0] VEC_INV  = 4'h9;
  localparam logic [3:0] VEC_PID  = 4'hA;
  localparam logic [3:0] VEC_WP   = 4'hB;

  localparam logic [1:0] ACC_RD = 2'b01;
  localparam logic [1:0] ACC_WR = 2'b10;

  typedef struct packed {
    logic [ADDR_W-1:0] hi;
    logic [ADDR_W-1:0] lo;
  } tlb_ent_t;
endpackage

// File: rtl/tlbl_store.sv
module tlbl_store
  import tlbl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 4,
  localparam int SETS    = 1 << SET_W,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [WAY_W-1:0]          wr_way,
  input  logic [SET_W-1:0]          wr_set,
  input  tlb_ent_t                  wr_ent,
  input  logic [SET_W-1:0]          rd_set,
  output tlb_ent_t [NUM_WAYS-1:0]   rd_ents
);
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_ent_t mem [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) mem[s] <= '0;
      end else if (wr_en && (wr_way == WAY_W'(w))) begin
        mem[wr_set] <= wr_ent;
      end
    end

    assign rd_ents[w] = mem[rd_set];
  end
endmodule

// File: rtl/tlbl_match.sv
module tlbl_match
  import tlbl_pkg::*;
#(
  parameter int NUM_WAYS = 4
) (
  input  tlb_ent_t [NUM_WAYS-1:0] ents,
  input  logic [VPN_W-1:0]        vpn,
  output logic                    hit,
  output tlb_ent_t                hit_ent
);
  // Scan from the top way down so the lowest matching way wins.
  always_comb begin
    hit     = 1'b0;
    hit_ent = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (ents[w].hi[ADDR_W-1:PAGE_BITS] == vpn) begin
        hit     = 1'b1;
        hit_ent = ents[w];
      end
    end
  end
endmodule

// File: rtl/tlbl_check.sv
module tlbl_check
  import tlbl_pkg::*;
(
  input  logic               hit,
  input  tlb_ent_t           ent,
  input  logic               is_write,
  input  logic [PID_W-1:0]   pid,
  input  logic [ADDR_W-1:0]  cfg,
  output logic               fault,
  output logic [3:0]         vec
);
  logic [PID_W-1:0] ent_pid;
  logic             pid_bad;

  assign ent_pid = ent.hi[PID_W-1:0];
  assign pid_bad = !ent.lo[FLG_G] && (ent_pid != PID_ANY) && (ent_pid != pid);

  always_comb begin
    vec = VEC_NONE;
    if (!hit)                                         vec = VEC_MISS;
    else if (cfg[CFG_V] && !ent.lo[FLG_V])            vec = VEC_INV;
    else if (pid_bad)                                 vec = VEC_PID;
    else if (is_write && cfg[CFG_W] && !ent.lo[FLG_W]) vec = VEC_WP;
  end

  assign fault = (vec != VEC_NONE);
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlbl_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int SET_W    = 4,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SEL_W   = SET_W + WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_en,
  input  logic [31:0]       mmu_cfg,
  input  logic [7:0]        cur_pid,
  input  logic              ld_en,
  input  logic [WAY_W-1:0]  ld_way,
  input  logic [SET_W-1:0]  ld_set,
  input  logic [31:0]       ld_hi,
  input  logic [31:0]       ld_lo,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_paddr,
  output logic              rsp_fault,
  output logic [3:0]        rsp_vec,
  output logic [31:0]       cause_q,
  output logic [SEL_W-1:0]  refill_sel
);
  logic [VPN_W-1:0]          vpn;
  logic [SET_W-1:0]          set_idx;
  tlb_ent_t [NUM_WAYS-1:0]   set_ents;
  tlb_ent_t                  ld_ent;
  tlb_ent_t                  hit_ent;
  logic                      hit;
  logic                      chk_fault;
  logic [3:0]                chk_vec;
  logic                      accept;
  logic                      nx_fault;
  logic [3:0]                nx_vec;
  logic [31:0]               nx_paddr;

  assign vpn     = req_vaddr[ADDR_W-1:PAGE_BITS];
  assign set_idx = vpn[SET_W-1:0];
  assign ld_ent  = '{hi: ld_hi, lo: ld_lo};

  tlbl_store #(.NUM_WAYS(NUM_WAYS), .SET_W(SET_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(ld_en), .wr_way(ld_way), .wr_set(ld_set),
    .wr_ent(ld_ent), .rd_set(set_idx), .rd_ents(set_ents)
  );

  tlbl_match #(.NUM_WAYS(NUM_WAYS)) u_match (
    .ents(set_ents), .vpn(vpn), .hit(hit), .hit_ent(hit_ent)
  );

  tlbl_check u_check (
    .hit(hit), .ent(hit_ent), .is_write(req_write), .pid(cur_pid), .cfg(mmu_cfg),
    .fault(chk_fault), .vec(chk_vec)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_comb begin
    if (!mmu_en) begin
      nx_fault = 1'b0;
      nx_vec   = VEC_NONE;
      nx_paddr = req_vaddr;
    end else begin
      nx_fault = chk_fault;
      nx_vec   = chk_vec;
      nx_paddr = chk_fault ? '0
                           : {hit_ent.lo[ADDR_W-1:PAGE_BITS], req_vaddr[PAGE_BITS-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_vec   <= VEC_NONE;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_paddr <= nx_paddr;
      rsp_fault <= nx_fault;
      rsp_vec   <= nx_vec;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q    <= '0;
      refill_sel <= '0;
    end else if (accept && nx_fault) begin
      cause_q <= {vpn, 3'b000, (req_write ? ACC_WR : ACC_RD), cur_pid};
      if (nx_vec == VEC_MISS) refill_sel <= {{WAY_W{1'b0}}, set_idx};
    end
  end

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_vec));

  // R11
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R8
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> (rsp_vec >= VEC_MISS) && (rsp_vec <= VEC_WP));

  // R4
  miss_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mmu_en && !hit |=> refill_sel == {{WAY_W{1'b0}}, $past(req_vaddr[PAGE_BITS+SET_W-1:PAGE_BITS])});

  // R9
  cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && nx_fault) |=> $stable(cause_q));

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !mmu_en |=> !rsp_fault && rsp_paddr == $past(req_vaddr));
endmodule

// File: tb/tb_tlb_lookup.sv
module tb_tlb_lookup;
  logic clk = 0, rst_n = 0;
  logic mmu_en = 1;
  logic [31:0] mmu_cfg = 0;
  logic [7:0] cur_pid = 0;
  logic ld_en = 0;
  logic [1:0] ld_way = 0;
  logic [3:0] ld_set = 0;
  logic [31:0] ld_hi = 0, ld_lo = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [31:0] req_vaddr = 0;
  logic req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr, cause_q;
  logic [3:0] rsp_vec;
  logic [5:0] refill_sel;

  int total = 0, bad = 0;
  logic [31:0] m_hi [4][16];
  logic [31:0] m_lo [4][16];
  logic [31:0] e_cause = 0;
  logic [5:0]  e_sel = 0;
  logic [18:0] tags [4] = '{19'h00000, 19'h12340, 19'h7abc0, 19'h55550};

  always #5 clk = ~clk;

  tlb_lookup dut (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .mmu_cfg(mmu_cfg), .cur_pid(cur_pid),
    .ld_en(ld_en), .ld_way(ld_way), .ld_set(ld_set), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_vec(rsp_vec), .cause_q(cause_q), .refill_sel(refill_sel)
  );

  task automatic check(input bit ok, input string tag, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  // Expected result from the requirements, updating the model's cause/select words.
  task automatic model(input logic [31:0] va, input logic wr, input logic en,
                       input logic [31:0] cfg, input logic [7:0] pid,
                       output logic [31:0] pa, output logic [3:0] vec, output string tag);
    logic [18:0] vpn = va[31:13];
    logic [3:0] idx = va[16:13];
    int hw = -1;
    for (int w = 3; w >= 0; w--) if (m_hi[w][idx][31:13] == vpn) hw = w;
    pa = 0; vec = 0;
    if (!en) begin pa = va; tag = "R2"; return; end
    if (hw < 0) begin vec = 4'h8; tag = "R4 R8"; end
    else begin
      logic [31:0] h = m_hi[hw][idx], l = m_lo[hw][idx];
      if (cfg[16] && !l[3]) begin vec = 4'h9; tag = "R5 R8"; end
      else if (!l[4] && h[7:0] != 8'hFF && h[7:0] != pid) begin vec = 4'hA; tag = "R6 R8"; end
      else if (wr && cfg[19] && !l[1]) begin vec = 4'hB; tag = "R7"; end
      else begin pa = {l[31:13], va[12:0]}; tag = "R3"; end
    end
    if (vec != 0) begin
      e_cause = {vpn, 3'b000, (wr ? 2'b10 : 2'b01), pid};
      if (vec == 4'h8) e_sel = {2'b00, idx};
    end
  endtask

  task automatic load(input int w, input int s, input logic [31:0] h, input logic [31:0] l);
    @(negedge clk);
    ld_en = 1; ld_way = 2'(w); ld_set = 4'(s); ld_hi = h; ld_lo = l;
    @(negedge clk);
    ld_en = 0;
    m_hi[w][s] = h; m_lo[w][s] = l;
  endtask

  task automatic access(input logic [31:0] va, input logic wr);
    logic [31:0] pa; logic [3:0] vec; string tag;
    model(va, wr, mmu_en, mmu_cfg, cur_pid, pa, vec, tag);
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid && rsp_paddr == pa && rsp_vec == vec && rsp_fault == (vec != 0), tag,
          $sformatf("va=%h wr=%0d got v=%0d pa=%h vec=%h exp pa=%h vec=%h",
                    va, wr, rsp_valid, rsp_paddr, rsp_vec, pa, vec));
    check(cause_q == e_cause && refill_sel == e_sel, "R9 R10",
          $sformatf("va=%h cause=%h sel=%h exp cause=%h sel=%h",
                    va, cause_q, refill_sel, e_cause, e_sel));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pa_a;
    void'($urandom(32'd1234));
    for (int w = 0; w < 4; w++) for (int s = 0; s < 16; s++) begin m_hi[w][s] = 0; m_lo[w][s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!rsp_valid && cause_q == 0 && refill_sel == 0, "R1",
          $sformatf("v=%0d cause=%h sel=%h exp 0", rsp_valid, cause_q, refill_sel));
    rst_n = 1;

    // R12 load then R3 hit, global valid writable entry
    mmu_cfg = 32'h0009_0000; cur_pid = 8'h21;
    load(2, 5, {19'h12345, 5'd0, 8'h21}, {19'h0abcd, 8'd0, 5'b11010});
    access({19'h12345, 13'h1abc}, 1'b1);
    // R4 miss: different tag, same set
    access({19'h7aa35, 13'h0004}, 1'b0);
    // R10 sel unchanged on WP fault; R7 write-protect
    load(0, 7, {19'h00007, 5'd0, 8'h21}, {19'h00042, 8'd0, 5'b01000});
    access({19'h00007, 13'h0010}, 1'b1);
    access({19'h00007, 13'h0010}, 1'b0); // R7 read does not fault
    // R8 lowest way wins on duplicate tag
    load(3, 9, {19'h11119, 5'd0, 8'hFF}, {19'h33333, 8'd0, 5'b11010});
    load(1, 9, {19'h11119, 5'd0, 8'hFF}, {19'h22222, 8'd0, 5'b11010});
    access({19'h11119, 13'h0777}, 1'b0);
    // R8 invalid beats PID
    load(0, 3, {19'h44443, 5'd0, 8'h99}, {19'h01010, 8'd0, 5'b00000});
    access({19'h44443, 13'h0001}, 1'b1);
    // R6 PID alone (check V disabled), then R5 with V enabled
    mmu_cfg = 32'h0008_0000;
    access({19'h44443, 13'h0001}, 1'b0);
    mmu_cfg = 32'h0001_0000;
    access({19'h44443, 13'h0002}, 1'b0);
    // R2 disabled passthrough
    mmu_en = 0;
    access(32'hdead_beef, 1'b1);
    mmu_en = 1;

    // R11 back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = {19'h12345, 13'h0001}; req_write = 0;
    @(negedge clk);
    pa_a = rsp_paddr;
    check(rsp_valid && pa_a == {19'h0abcd, 13'h0001}, "R11",
          $sformatf("first pa=%h exp %h", pa_a, {19'h0abcd, 13'h0001}));
    req_vaddr = 32'h0000_2000; // a different request waits
    check(!req_ready, "R11", $sformatf("req_ready=%0d exp 0", req_ready));
    @(negedge clk);
    check(rsp_valid && rsp_paddr == pa_a, "R11",
          $sformatf("held pa=%h exp %h", rsp_paddr, pa_a));
    mmu_en = 0; rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check(rsp_valid && rsp_paddr == 32'h0000_2000, "R11",
          $sformatf("second pa=%h exp 00002000", rsp_paddr));
    mmu_en = 1;

    // Random mix
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 3 == 0) begin
        int s = $urandom % 16;
        logic [18:0] t = tags[$urandom % 4] | 19'(s);
        logic [7:0] p;
        case ($urandom % 3) 0: p = 8'h21; 1: p = 8'hFF; default: p = 8'h5c; endcase
        load($urandom % 4, s, {t, 5'd0, p}, {19'($urandom), 8'd0, 5'($urandom)});
      end
      mmu_cfg = {12'd0, 1'($urandom), 2'b00, 1'($urandom), 16'd0};
      cur_pid = ($urandom % 2) ? 8'h21 : 8'h5c;
      mmu_en  = ($urandom % 10) != 0;
      access({tags[$urandom % 4] | 19'($urandom % 16), 13'($urandom)}, 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule